// File: doc/BRIEF.md
# Bit-Stream Field Reader

This block pulls variable-length fields out of a bit stream that is spread over two 16-bit RAM banks. Stream word `k` sits in bank `k mod 2` at address `k/2`. A word pointer and a bit-position pointer mark the next unread bit. On each request the block reads the word under the pointer and the word after it in one RAM cycle, one from each bank. It puts the two words into stream order when the first one came from the odd bank. It then cuts an `n`-bit field, with `n` from 1 to 16, out of the 32-bit pair and returns it right-justified.

Two bit orders are supported. In MSB-first order each word is consumed from bit 15 down to bit 0. In LSB-first order each word is consumed from bit 0 up to bit 15. In both orders a field may run past the end of one word into the next. After each read the pointers advance by `n`, so back-to-back requests walk the stream without gaps. A seek input places the pointers at any word and bit.

Top module: `bsx_reader`

## Requirements
- R1: After reset `busy`, `res_valid`, `res_data`, `word_ptr` and `bit_ptr` are all zero.
- R2: While a read is in progress, `bank1_addr` equals `word_ptr >> 1` and `bank0_addr` equals `(word_ptr + 1) >> 1`, both taken modulo 2^ADDR_W. Stream word k is held in bank k mod 2 at address k/2.
- R3: With `req_lsb_first` = 0 (MSB-first), let the stream bit at linear index j = 16*w + b be bit 15-b of word w. Then result bit n-1-i equals stream bit (16*word_ptr + bit_ptr + i), for i = 0..n-1.
- R4: With `req_lsb_first` = 1 (LSB-first), let stream bit j = 16*w + b be bit b of word w. Then result bit i equals stream bit (16*word_ptr + bit_ptr + i).
- R5: A field with bit_ptr + n > 16 crosses into word word_ptr+1 and is still returned correctly in both orders. Word indices wrap modulo 2^(ADDR_W+1).
- R6: Result bits n and above are zero. `req_len` is a 5-bit binary value from 1 to 16.
- R7: `res_valid` is a one-cycle pulse. It rises on the 3rd clock edge after the edge that accepts a request when word_ptr is even, and on the 4th when word_ptr is odd.
- R8: `busy` is high from the edge that accepts a request up to the edge on which `res_valid` rises. It is low while idle.
- R9: On the edge where `res_valid` rises, the linear position 16*word_ptr + bit_ptr increases by n. `bit_ptr` always stays in 0..15.
- R10: A request made while `busy` is high is ignored. It produces no extra result and does not change the pointer update.
- R11: A seek made while idle loads `word_ptr`/`bit_ptr` from `seek_word`/`seek_bit` on the next edge, and a request in the same cycle is dropped. A seek made while busy is ignored.
- R12: `res_data` keeps its value until the next `res_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request, taken when idle |
| req_len | input | 5 | Field length n, 1..16 |
| req_lsb_first | input | 1 | 0: MSB-first, 1: LSB-first bit order |
| seek_valid | input | 1 | Load the pointers, taken when idle |
| seek_word | input | ADDR_W+1 | Word pointer value to load |
| seek_bit | input | 4 | Bit pointer value to load |
| bank0_addr | output | ADDR_W | Read address of the even-word bank |
| bank0_rdata | input | 16 | Read data of the even-word bank, one cycle after its address |
| bank1_addr | output | ADDR_W | Read address of the odd-word bank |
| bank1_rdata | input | 16 | Read data of the odd-word bank, one cycle after its address |
| busy | output | 1 | A read is in progress |
| res_valid | output | 1 | One-cycle pulse: `res_data` holds a new field |
| res_data | output | 16 | Right-justified field |
| word_ptr | output | ADDR_W+1 | Current stream word pointer |
| bit_ptr | output | 5 | Current bit position, always 0..15 |

## Verification
The assertions rely on three conditions on the inputs:
- `req_len` lies between 1 and 16.
- Both banks return data exactly one clock after the address is presented.
- The bank contents do not change while a read is in flight.

The bench RAM model has a registered read and is loaded once before reset, so the last two always hold. Every request uses a length from the legal 1..16 range. The stray requests and seeks injected during a busy read also stay within these limits, so any assertion that fires points at the design and not at the stimulus.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
  localparam int WORD_W = 16;
  localparam int LONG_W = 2 * WORD_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int POS_W  = BIT_W + 1;
  localparam int LEN_W  = BIT_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CAPTURE,
    ST_SWAP,
    ST_SHIFT
  } bsx_state_e;

  // Cut a field out of an ordered pair {first, second}.
  function automatic logic [WORD_W-1:0] bsx_cut(
    input logic [LONG_W-1:0] pair,
    input logic [BIT_W-1:0]  pos,
    input logic [LEN_W-1:0]  len,
    input logic              lsb_first
  );
    logic [LONG_W-1:0] t;
    logic [WORD_W:0]   m;
    logic [WORD_W-1:0] r;
    if (!lsb_first) begin
      t = pair << pos;
      r = t[LONG_W-1 -: WORD_W] >> (WORD_W - int'(len));
    end else begin
      t = {pair[WORD_W-1:0], pair[LONG_W-1 -: WORD_W]} >> pos;
      m = ({{WORD_W{1'b0}}, 1'b1} << len) - 1'b1;
      r = t[WORD_W-1:0] & m[WORD_W-1:0];
    end
    return r;
  endfunction

  // Bit position plus length; the top bit is the word carry.
  function automatic logic [POS_W-1:0] bsx_step(
    input logic [BIT_W-1:0] pos,
    input logic [LEN_W-1:0] len
  );
    return {1'b0, pos} + len;
  endfunction
endpackage

// File: rtl/bsx_ctrl.sv
module bsx_ctrl
  import bsx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_lsb_first,
  input  logic             seek_valid,
  input  logic             odd_word,
  output logic             busy,
  output logic             accept,
  output logic             seek_apply,
  output logic             capture,
  output logic             reorder,
  output logic             finish,
  output logic [LEN_W-1:0] len_q,
  output logic             lsb_q
);
  bsx_state_e state_q, state_d;
  logic idle;

  assign idle       = (state_q == ST_IDLE);
  assign busy       = !idle;
  assign seek_apply = idle && seek_valid;
  assign accept     = idle && req_valid && !seek_valid;
  assign capture    = (state_q == ST_CAPTURE);
  assign reorder    = (state_q == ST_SWAP);
  assign finish     = (state_q == ST_SHIFT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_ISSUE;
      ST_ISSUE:   state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = odd_word ? ST_SWAP : ST_SHIFT;
      ST_SWAP:    state_d = ST_SHIFT;
      ST_SHIFT:   state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      lsb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        len_q <= req_len;
        lsb_q <= req_lsb_first;
      end
    end
  end

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);
  assert_events_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept, seek_apply, capture, reorder, finish}));
  assert_swap_only_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reorder |-> odd_word);
  assert_request_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(len_q) && $stable(lsb_q)));
endmodule

// File: rtl/bsx_ptr.sv
module bsx_ptr
  import bsx_pkg::*;
#(
  parameter int WP_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seek_apply,
  input  logic [WP_W-1:0]  seek_word,
  input  logic [BIT_W-1:0] seek_bit,
  input  logic             finish,
  input  logic             busy,
  input  logic [LEN_W-1:0] len,
  output logic [WP_W-1:0]  word_ptr,
  output logic [POS_W-1:0] bit_ptr,
  output logic             odd_word
);
  localparam int LIN_W = WP_W + BIT_W;

  logic [WP_W-1:0]  word_q;
  logic [POS_W-1:0] bit_q;
  logic [POS_W-1:0] step;
  logic [WP_W-1:0]  carry;

  assign step     = bsx_step(bit_q[BIT_W-1:0], len);
  assign carry    = {{(WP_W-1){1'b0}}, step[BIT_W]};
  assign word_ptr = word_q;
  assign bit_ptr  = bit_q;
  assign odd_word = word_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bit_q  <= '0;
    end else if (seek_apply) begin
      word_q <= seek_word;
      bit_q  <= {1'b0, seek_bit};
    end else if (finish) begin
      word_q <= word_q + carry;
      bit_q  <= {1'b0, step[BIT_W-1:0]};
    end
  end

  logic [LIN_W-1:0] lin_pos;
  logic [LIN_W-1:0] lin_len;
  assign lin_pos = {word_q, bit_q[BIT_W-1:0]};
  assign lin_len = {{(WP_W-1){1'b0}}, len};

  assert_bit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q[BIT_W] == 1'b0);
  assert_linear_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (lin_pos == $past(lin_pos) + $past(lin_len)));
  assert_hold_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> ($stable(word_q) && $stable(bit_q)));
endmodule

// File: rtl/bsx_fetch.sv
module bsx_fetch
  import bsx_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WP_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WP_W-1:0]   word_ptr,
  input  logic              capture,
  input  logic              reorder,
  input  logic [WORD_W-1:0] bank0_rdata,
  input  logic [WORD_W-1:0] bank1_rdata,
  output logic [ADDR_W-1:0] bank0_addr,
  output logic [ADDR_W-1:0] bank1_addr,
  output logic [LONG_W-1:0] pair_q
);
  logic [ADDR_W-1:0] row;
  logic [ADDR_W-1:0] odd_inc;

  // Odd banks hold word k at k/2; the even bank holds the pair's other word.
  assign row        = word_ptr[ADDR_W:1];
  assign odd_inc    = {{(ADDR_W-1){1'b0}}, word_ptr[0]};
  assign bank1_addr = row;
  assign bank0_addr = row + odd_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else if (capture) begin
      pair_q <= {bank0_rdata, bank1_rdata};
    end else if (reorder) begin
      pair_q <= {pair_q[WORD_W-1:0], pair_q[LONG_W-1:WORD_W]};
    end
  end

  assert_swap_halves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reorder |=> (pair_q == {$past(pair_q[WORD_W-1:0]), $past(pair_q[LONG_W-1:WORD_W])}));
  assert_addr_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> ($stable(bank0_addr) && $stable(bank1_addr)));
endmodule

// File: rtl/bsx_extract.sv
module bsx_extract
  import bsx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              finish,
  input  logic [LONG_W-1:0] pair,
  input  logic [BIT_W-1:0]  pos,
  input  logic [LEN_W-1:0]  len,
  input  logic              lsb_first,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= finish;
      if (finish) res_data <= bsx_cut(pair, pos, len, lsb_first);
    end
  end

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_data >> len) == '0));
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_data_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(res_data));
endmodule

// File: rtl/bsx_reader.sv
module bsx_reader
  import bsx_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int WP_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_lsb_first,
  input  logic              seek_valid,
  input  logic [WP_W-1:0]   seek_word,
  input  logic [BIT_W-1:0]  seek_bit,
  output logic [ADDR_W-1:0] bank0_addr,
  input  logic [WORD_W-1:0] bank0_rdata,
  output logic [ADDR_W-1:0] bank1_addr,
  input  logic [WORD_W-1:0] bank1_rdata,
  output logic              busy,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data,
  output logic [WP_W-1:0]   word_ptr,
  output logic [POS_W-1:0]  bit_ptr
);
  logic             accept, seek_apply, capture, reorder, finish;
  logic             odd_word, lsb_q;
  logic [LEN_W-1:0] len_q;
  logic [LONG_W-1:0] pair_q;

  bsx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_len(req_len), .req_lsb_first(req_lsb_first),
    .seek_valid(seek_valid), .odd_word(odd_word),
    .busy(busy), .accept(accept), .seek_apply(seek_apply),
    .capture(capture), .reorder(reorder), .finish(finish),
    .len_q(len_q), .lsb_q(lsb_q)
  );

  bsx_ptr #(.WP_W(WP_W)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .seek_apply(seek_apply), .seek_word(seek_word), .seek_bit(seek_bit),
    .finish(finish), .busy(busy), .len(len_q),
    .word_ptr(word_ptr), .bit_ptr(bit_ptr), .odd_word(odd_word)
  );

  bsx_fetch #(.ADDR_W(ADDR_W), .WP_W(WP_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .word_ptr(word_ptr), .capture(capture), .reorder(reorder),
    .bank0_rdata(bank0_rdata), .bank1_rdata(bank1_rdata),
    .bank0_addr(bank0_addr), .bank1_addr(bank1_addr), .pair_q(pair_q)
  );

  bsx_extract u_extract (
    .clk(clk), .rst_n(rst_n),
    .finish(finish), .pair(pair_q), .pos(bit_ptr[BIT_W-1:0]),
    .len(len_q), .lsb_first(lsb_q),
    .res_valid(res_valid), .res_data(res_data)
  );

  assert_idle_after_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
  assert_accept_starts_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
endmodule

// File: tb/bsx_reader_tb.sv
`timescale 1ns/1ps
module bsx_reader_tb;
  localparam int ADDR_W = 4;
  localparam int WP_W   = ADDR_W + 1;
  localparam int NWORDS = 1 << WP_W;
  localparam int NROWS  = 1 << ADDR_W;
  localparam int NBITS  = NWORDS * 16;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_lsb_first, seek_valid;
  logic [4:0] req_len;
  logic [WP_W-1:0] seek_word;
  logic [3:0] seek_bit;
  logic [ADDR_W-1:0] bank0_addr, bank1_addr;
  logic [15:0] bank0_rdata, bank1_rdata;
  logic busy, res_valid;
  logic [15:0] res_data;
  logic [WP_W-1:0] word_ptr;
  logic [4:0] bit_ptr;

  logic [15:0] mem0 [NROWS];
  logic [15:0] mem1 [NROWS];

  int checks = 0;
  int errors = 0;
  int lin = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    bank0_rdata <= mem0[bank0_addr];
    bank1_rdata <= mem1[bank1_addr];
  end

  bsx_reader #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_len(req_len), .req_lsb_first(req_lsb_first),
    .seek_valid(seek_valid), .seek_word(seek_word), .seek_bit(seek_bit),
    .bank0_addr(bank0_addr), .bank0_rdata(bank0_rdata),
    .bank1_addr(bank1_addr), .bank1_rdata(bank1_rdata),
    .busy(busy), .res_valid(res_valid), .res_data(res_data),
    .word_ptr(word_ptr), .bit_ptr(bit_ptr)
  );

  function automatic logic [15:0] word_val(input int k);
    logic [31:0] v;
    v = (k * 32'd40503 + 32'd23123) ^ (k << 11);
    return v[23:8];
  endfunction

  function automatic logic sbit(input int j, input bit lsb);
    logic [15:0] v;
    int b;
    v = word_val((j / 16) % NWORDS);
    b = j % 16;
    return lsb ? v[b] : v[15-b];
  endfunction

  function automatic logic [15:0] expect_field(input int start, input int n, input bit lsb);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < n; i++) begin
      if (lsb) r[i] = sbit(start + i, lsb);
      else     r[n-1-i] = sbit(start + i, lsb);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_ptrs(input string req);
    chk(int'(word_ptr) == (lin / 16) % NWORDS, req, "word_ptr", word_ptr, (lin / 16) % NWORDS);
    chk(int'(bit_ptr) == lin % 16, req, "bit_ptr", bit_ptr, lin % 16);
  endtask

  task automatic do_seek(input int w, input int b);
    @(negedge clk);
    seek_valid = 1'b1;
    seek_word  = WP_W'(w);
    seek_bit   = 4'(b);
    @(posedge clk);
    @(negedge clk);
    seek_valid = 1'b0;
    lin = w * 16 + b;
    check_ptrs("R11");
  endtask

  // disturb: 0 none, 1 request while busy, 2 seek while busy
  task automatic do_read(input int n, input bit lsb, input int disturb);
    logic [15:0] e;
    int w, p, lat, exp_lat;
    bit seen;
    w = (lin / 16) % NWORDS;
    p = lin % 16;
    e = expect_field(lin, n, lsb);
    exp_lat = (w % 2 == 1) ? 4 : 3;
    @(negedge clk);
    req_valid     = 1'b1;
    req_len       = 5'(n);
    req_lsb_first = lsb;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
    chk(int'(bank1_addr) == (w / 2) % NROWS, "R2", "bank1_addr", bank1_addr, (w / 2) % NROWS);
    chk(int'(bank0_addr) == ((w + 1) / 2) % NROWS, "R2", "bank0_addr", bank0_addr, ((w + 1) / 2) % NROWS);
    if (disturb == 1) begin
      req_valid = 1'b1; req_len = 5'd3; req_lsb_first = !lsb;
    end else if (disturb == 2) begin
      seek_valid = 1'b1; seek_word = WP_W'(w ^ 5); seek_bit = 4'(p ^ 9);
    end
    lat = 0;
    seen = 1'b0;
    for (int c = 0; c < 8 && !seen; c++) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      if (res_valid) seen = 1'b1;
      else chk(busy == 1'b1, "R8", "busy during read", busy, 1);
    end
    req_valid  = 1'b0;
    seek_valid = 1'b0;
    chk(seen && lat == exp_lat, "R7", "valid latency", lat, exp_lat);
    chk(res_data == e, lsb ? "R4" : "R3", "field", res_data, e);
    if (p + n > 16) chk(res_data == e, "R5", "straddling field", res_data, e);
    chk((res_data >> n) == 16'h0, "R6", "upper bits", res_data >> n, 0);
    chk(busy == 1'b0, "R8", "busy at result", busy, 0);
    lin = (lin + n) % NBITS;
    check_ptrs(disturb == 1 ? "R10" : (disturb == 2 ? "R11" : "R9"));
    chk(bit_ptr < 5'd16, "R9", "bit_ptr range", bit_ptr, 15);
    @(negedge clk);
    chk(res_valid == 1'b0, "R10", "no second result", res_valid, 0);
    chk(busy == 1'b0, "R10", "no late accept", busy, 0);
    chk(res_data == e, "R12", "result held", res_data, e);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_len = 5'd1; req_lsb_first = 1'b0;
    seek_valid = 1'b0; seek_word = '0; seek_bit = '0;
    for (int k = 0; k < NWORDS; k++) begin
      if (k % 2 == 0) mem0[k/2] = word_val(k);
      else            mem1[k/2] = word_val(k);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(busy == 1'b0, "R1", "busy", busy, 0);
    chk(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
    chk(res_data == 16'h0, "R1", "res_data", res_data, 0);
    chk(word_ptr == '0, "R1", "word_ptr", word_ptr, 0);
    chk(bit_ptr == '0, "R1", "bit_ptr", bit_ptr, 0);

    // Sweep of order, start bit and length, odd and even words, including wrap
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 16; p++)
        for (int n = 1; n <= 16; n++) begin
          do_seek((p * 7 + n * 3 + m) % NWORDS, p);
          do_read(n, bit'(m), 0);
        end

    // Seamless successive reads across the whole stream and its wrap
    for (int m = 0; m < 2; m++) begin
      do_seek(m * 3, m * 5);
      for (int i = 0; i < 70; i++) do_read((i * 5) % 16 + 1, bit'(m), 0);
    end

    // Requests and seeks while busy are ignored (R10, R11)
    do_seek(6, 13);
    do_read(9, 1'b0, 1);
    do_read(12, 1'b1, 1);
    do_read(5, 1'b0, 2);
    do_read(16, 1'b1, 2);

    // R11: seek wins over a request in the same cycle
    @(negedge clk);
    seek_valid = 1'b1; seek_word = WP_W'(9); seek_bit = 4'd5;
    req_valid = 1'b1; req_len = 5'd4;
    @(posedge clk);
    @(negedge clk);
    seek_valid = 1'b0; req_valid = 1'b0;
    lin = 9 * 16 + 5;
    chk(busy == 1'b0, "R11", "request dropped", busy, 0);
    check_ptrs("R11");
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk(res_valid == 1'b0, "R11", "no result from dropped request", res_valid, 0);
    end

    // R12: result held over idle cycles
    do_read(11, 1'b1, 0);
    begin
      logic [15:0] held;
      held = res_data;
      repeat (6) @(negedge clk);
      chk(res_data == held, "R12", "idle hold", res_data, held);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end
endmodule